// File: doc/BRIEF.md
# Memory Configuration Register Access Port

This block is the device-side front end that lets a host reach the mode registers of a burst pseudo-static memory. When a dedicated configuration-enable input is already high at the start of a bus access, the access is steered away from the memory array. It goes to one of three 16-bit registers instead, chosen by two upper address bits. Two of these registers hold host-programmable settings, one for the bus interface and one for refresh. The third is a fixed identification word that can only be read.

All strobes are sampled on the block clock, and the outputs are registered. A register write never takes its value from the data bus. In synchronous mode, the low 16 address lines are captured on the first rising edge of the address-latch, chip-enable or write-enable strobe, and the write is committed when chip enable is released. In asynchronous mode, an address-latch pulse commits the address lines present at its falling edge. Reads drive the selected register onto a data output with a separate drive enable, and work the same way in both modes.

Top module: `cfg_access_port`

## Requirements
- R1: After synchronous reset, the bus settings register holds BUS_RST (default 16'h9D4F), the refresh settings register holds RFSH_RST (default 16'h0010), and dq_oe is 0.
- R2: Register selection uses addr[18] and addr[19]. With addr[18]=1 the identification register is selected whatever addr[19] is. With addr[18]=0, addr[19]=0 selects the bus settings register and addr[19]=1 selects the refresh settings register.
- R3: On every clock edge where ce and oe are both high inside a configuration access, the next output cycle shows dq_oe=1 and dq_out equal to the selected register. In every other case dq_oe is 0 on the next cycle.
- R4: An access is a configuration access only if cfg_en is high at the first rising edge of adv, ce or we after all three strobes were low. If cfg_en rises later in the access, no data is driven and no register is written.
- R5: In synchronous mode (sync_mode=1), addr[15:0] and the register selection are captured at the first rising strobe edge of the access. Later rising edges in the same access do not capture again. The captured value is written on the clock edge where ce is first sampled low, provided we was high together with ce at some sampled edge of the access.
- R6: In asynchronous mode (sync_mode=0), the clock edge where adv is sampled low after being high writes addr[15:0] to the selected register, provided ce and we are high in a configuration access. An adv pulse with we low writes nothing.
- R7: The identification register always reads IDENT_VAL (default 16'h0A5C), and writes that select it change no register.
- R8: The byte-enable inputs be[1:0] have no effect on register reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration-enable; high at access start redirects the access to the registers |
| sync_mode | input | 1 | 1 selects synchronous write capture, 0 selects asynchronous latch-pulse writes |
| ce | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable, active high |
| we | input | 1 | Write enable, active high |
| adv | input | 1 | Address-latch strobe, active high |
| be | input | 2 | Byte-lane enables, ignored by register accesses |
| addr | input | 20 | Address bus; [15:0] carries write values, [18] and [19] select the register |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 1 | Registered drive enable for dq_out; low means the bus is released |

## Verification
The bench looks for the failures a strobe-ordering design is most likely to have. It runs synchronous writes where adv, ce or we each rises first and the address changes on every later edge. A design that recaptures on a later edge, or ignores the edge order, stores one of the decoy values. It raises cfg_en only after the access has begun, which catches a design that samples cfg_en as a plain level: that design would drive the bus or change a register. It also writes with addr[18] set under both values of addr[19], and pulses adv with we low, so a design that decodes only addr[19] or commits every latch pulse overwrites a settings register. Random mixes of modes, selections, byte enables and data are checked against a model of the two settings registers.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    REG_BUS   = 2'd0,
    REG_RFSH  = 2'd1,
    REG_IDENT = 2'd2
  } reg_sel_e;

  // Identification bit dominates; otherwise the pick bit chooses.
  function automatic reg_sel_e decode_sel(input logic id_bit, input logic pick_bit);
    if (id_bit)
      return REG_IDENT;
    else if (pick_bit)
      return REG_RFSH;
    else
      return REG_BUS;
  endfunction

endpackage

// File: rtl/cfg_strobe_track.sv
module cfg_strobe_track
  import cfgport_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              sync_mode,
  input  logic              ce,
  input  logic              adv,
  input  logic              we,
  input  logic [DATA_W-1:0] val,
  input  logic              id_bit,
  input  logic              pick_bit,
  output logic              cfg_cur,
  output logic              wr_commit,
  output reg_sel_e          wr_sel,
  output logic [DATA_W-1:0] wr_data
);

  logic              adv_q, ce_q, we_q;
  logic              captured_q, lat_q, wr_seen_q;
  logic [DATA_W-1:0] hold_data_q;
  reg_sel_e          hold_sel_q;

  logic any_rise, first_edge, idle, sync_fire, async_fire;

  always_comb begin
    any_rise   = (adv & ~adv_q) | (ce & ~ce_q) | (we & ~we_q);
    first_edge = any_rise & ~captured_q;
    idle       = ~adv & ~ce & ~we;
    cfg_cur    = captured_q ? lat_q : (first_edge & cfg_en);
    sync_fire  = sync_mode & ce_q & ~ce & captured_q & lat_q & wr_seen_q;
    async_fire = ~sync_mode & adv_q & ~adv & ce & we & cfg_cur;
    wr_commit  = sync_fire | async_fire;
    if (sync_fire) begin
      wr_sel  = hold_sel_q;
      wr_data = hold_data_q;
    end else begin
      wr_sel  = decode_sel(id_bit, pick_bit);
      wr_data = val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_q       <= 1'b0;
      ce_q        <= 1'b0;
      we_q        <= 1'b0;
      captured_q  <= 1'b0;
      lat_q       <= 1'b0;
      wr_seen_q   <= 1'b0;
      hold_data_q <= '0;
      hold_sel_q  <= REG_BUS;
    end else begin
      adv_q <= adv;
      ce_q  <= ce;
      we_q  <= we;
      if (idle) begin
        captured_q <= 1'b0;
        lat_q      <= 1'b0;
        wr_seen_q  <= 1'b0;
      end else begin
        if (first_edge) begin
          captured_q  <= 1'b1;
          lat_q       <= cfg_en;
          hold_data_q <= val;
          hold_sel_q  <= decode_sel(id_bit, pick_bit);
        end
        if (ce & we)
          wr_seen_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfgport_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] BUS_RST   = 16'h9D4F,
  parameter logic [DATA_W-1:0] RFSH_RST  = 16'h0010,
  parameter logic [DATA_W-1:0] IDENT_VAL = 16'h0A5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  reg_sel_e          rd_sel,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [DATA_W-1:0] bus_q, rfsh_q, rd_val;

  always_comb begin
    unique case (rd_sel)
      REG_BUS:  rd_val = bus_q;
      REG_RFSH: rd_val = rfsh_q;
      default:  rd_val = IDENT_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= BUS_RST;
      rfsh_q <= RFSH_RST;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (wr_commit) begin
        if (wr_sel == REG_BUS)
          bus_q <= wr_data;
        else if (wr_sel == REG_RFSH)
          rfsh_q <= wr_data;
      end
      dq_oe  <= rd_en;
      dq_out <= rd_en ? rd_val : '0;
    end
  end

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgport_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                ID_BIT    = 18,
  parameter int                PICK_BIT  = 19,
  parameter logic [DATA_W-1:0] BUS_RST   = 16'h9D4F,
  parameter logic [DATA_W-1:0] RFSH_RST  = 16'h0010,
  parameter logic [DATA_W-1:0] IDENT_VAL = 16'h0A5C,
  localparam int               BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              sync_mode,
  input  logic              ce,
  input  logic              oe,
  input  logic              we,
  input  logic              adv,
  input  logic [BE_W-1:0]   be,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              cfg_cur;
  logic              wr_commit;
  reg_sel_e          wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic              rd_en;
  reg_sel_e          rd_sel;
  logic              unused_lanes;

  // Byte lanes and the address bits between the value field and the
  // select bits take no part in register accesses.
  assign unused_lanes = ^{be, addr};

  assign rd_en  = ce & oe & cfg_cur;
  assign rd_sel = decode_sel(addr[ID_BIT], addr[PICK_BIT]);

  cfg_strobe_track #(.DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .sync_mode (sync_mode),
    .ce        (ce),
    .adv       (adv),
    .we        (we),
    .val       (addr[DATA_W-1:0]),
    .id_bit    (addr[ID_BIT]),
    .pick_bit  (addr[PICK_BIT]),
    .cfg_cur   (cfg_cur),
    .wr_commit (wr_commit),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data)
  );

  cfg_reg_bank #(
    .DATA_W    (DATA_W),
    .BUS_RST   (BUS_RST),
    .RFSH_RST  (RFSH_RST),
    .IDENT_VAL (IDENT_VAL)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/cfg_access_port_sva.sv
module cfg_access_port_sva #(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] IDENT_VAL = 16'h0A5C
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              oe,
  input logic              we,
  input logic              adv,
  input logic              sync_mode,
  input logic              addr_id,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              wr_commit
);

  assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(ce && oe));

  assert_ident_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(addr_id)) |-> (dq_out == IDENT_VAL));

  assert_sync_commit_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && sync_mode) |-> (!ce && $past(ce)));

  assert_async_commit_on_latch_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !sync_mode) |-> (!adv && $past(adv) && ce && we));

  assert_quiet_bus_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!ce && !adv && !we && !$past(ce)) |-> !wr_commit);

endmodule

bind cfg_access_port cfg_access_port_sva #(
  .DATA_W    (DATA_W),
  .IDENT_VAL (IDENT_VAL)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .oe        (oe),
  .we        (we),
  .adv       (adv),
  .sync_mode (sync_mode),
  .addr_id   (addr[ID_BIT]),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .wr_commit (wr_commit)
);

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb;

  localparam logic [15:0] BUS_RST   = 16'h9D4F;
  localparam logic [15:0] RFSH_RST  = 16'h0010;
  localparam logic [15:0] IDENT_VAL = 16'h0A5C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, sync_mode = 1'b0;
  logic        ce = 1'b0, oe = 1'b0, we = 1'b0, adv = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [19:0] addr = '0;
  logic [15:0] dq_out;
  logic        dq_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [15:0] m_bus, m_rfsh;

  always #5 clk = ~clk;

  cfg_access_port u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .sync_mode(sync_mode),
    .ce(ce), .oe(oe), .we(we), .adv(adv), .be(be), .addr(addr),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [19:0] mk_addr(input logic pick, input logic id, input logic [15:0] v);
    return {pick, id, 2'($urandom), v};
  endfunction

  function automatic logic [15:0] exp_reg(input logic pick, input logic id);
    if (id) return IDENT_VAL;
    return pick ? m_rfsh : m_bus;
  endfunction

  function automatic logic [15:0] junk(input logic [15:0] v);
    return v ^ 16'hFFFF ^ 16'($urandom);
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    @(negedge clk);
    ce = 0; oe = 0; we = 0; adv = 0; cfg_en = 0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic pick, input logic id, input string tag);
    @(negedge clk);
    cfg_en = 1; addr = mk_addr(pick, id, 16'($urandom)); be = 2'($urandom);
    @(negedge clk);
    ce = 1; oe = 1;
    @(negedge clk);
    chk(tag, {dq_oe, dq_out}, {1'b1, exp_reg(pick, id)});
    bus_idle();
  endtask

  // order 0: ce first, 1: adv first, 2: we first
  task automatic sync_write(input int order, input logic pick, input logic id, input logic [15:0] v);
    @(negedge clk);
    sync_mode = 1; cfg_en = 1; be = 2'($urandom);
    @(negedge clk);
    addr = mk_addr(pick, id, v);
    if (order == 0) ce = 1; else if (order == 1) adv = 1; else we = 1;
    @(negedge clk);
    addr = mk_addr(~pick, 1'b0, junk(v));
    if (order == 0) adv = 1; else ce = 1;
    @(negedge clk);
    addr = mk_addr(~pick, 1'b0, junk(v));
    if (order == 2) adv = 1; else we = 1;
    @(negedge clk);
    ce = 0; adv = 0; we = 0; addr = mk_addr(~pick, 1'b0, junk(v));
    @(negedge clk);
    cfg_en = 0;
    if (!id) begin
      if (pick) m_rfsh = v; else m_bus = v;
    end
  endtask

  task automatic async_write(input logic pick, input logic id, input logic [15:0] v, input logic with_we);
    @(negedge clk);
    sync_mode = 0; cfg_en = 1; be = 2'($urandom);
    @(negedge clk);
    ce = 1; we = with_we; addr = mk_addr(pick, id, v);
    @(negedge clk);
    adv = 1;
    @(negedge clk);
    adv = 0;
    @(negedge clk);
    ce = 0; we = 0; addr = mk_addr(~pick, 1'b0, junk(v));
    @(negedge clk);
    cfg_en = 0;
    if (!id && with_we) begin
      if (pick) m_rfsh = v; else m_bus = v;
    end
  endtask

  initial begin
    void'($urandom(32'd4099));
    m_bus = BUS_RST;
    m_rfsh = RFSH_RST;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    chk("R1 dq_oe after reset", {16'h0, dq_oe}, 17'h0);
    do_read(1'b0, 1'b0, "R1 bus reset value");
    do_read(1'b1, 1'b0, "R1 refresh reset value");
    // R2 / R7: identification under both addr[19] values
    do_read(1'b0, 1'b1, "R2 ident with addr19=0");
    do_read(1'b1, 1'b1, "R2 ident with addr19=1");

    // R5: edge ordering, later edges must not recapture
    sync_write(0, 1'b0, 1'b0, 16'h1234);
    do_read(1'b0, 1'b0, "R5 sync ce-first capture");
    sync_write(1, 1'b1, 1'b0, 16'hBEEF);
    do_read(1'b1, 1'b0, "R5 sync adv-first capture");
    sync_write(2, 1'b0, 1'b0, 16'h0F0F);
    do_read(1'b0, 1'b0, "R5 sync we-first capture");

    // R6: async commit and latch pulse without we
    async_write(1'b1, 1'b0, 16'h5A5A, 1'b1);
    do_read(1'b1, 1'b0, "R6 async latch write");
    async_write(1'b0, 1'b0, 16'hDEAD, 1'b0);
    do_read(1'b0, 1'b0, "R6 latch pulse without we ignored");

    // R7: writes to identification in both modes
    sync_write(0, 1'b0, 1'b1, 16'h7777);
    async_write(1'b1, 1'b1, 16'h6666, 1'b1);
    do_read(1'b0, 1'b1, "R7 ident unchanged");
    do_read(1'b0, 1'b0, "R7 bus unaffected by ident write");
    do_read(1'b1, 1'b0, "R7 refresh unaffected by ident write");

    // R8: zero byte enables still write
    @(negedge clk);
    sync_mode = 1; cfg_en = 1;
    @(negedge clk);
    be = 2'b00; ce = 1; addr = mk_addr(1'b1, 1'b0, 16'hC3C3);
    @(negedge clk);
    we = 1;
    @(negedge clk);
    ce = 0; we = 0;
    m_rfsh = 16'hC3C3;
    bus_idle();
    do_read(1'b1, 1'b0, "R8 write with be=00");

    // R4: cfg_en raised after the access started
    @(negedge clk);
    sync_mode = 1; cfg_en = 0;
    @(negedge clk);
    ce = 1; we = 1; addr = mk_addr(1'b0, 1'b0, 16'h4444);
    @(negedge clk);
    cfg_en = 1; adv = 1;
    @(negedge clk);
    bus_idle();
    do_read(1'b0, 1'b0, "R4 late cfg_en write ignored");
    @(negedge clk);
    ce = 1; oe = 1; addr = mk_addr(1'b0, 1'b1, 16'h0);
    @(negedge clk);
    cfg_en = 1;
    @(negedge clk);
    chk("R4 late cfg_en read not driven", {16'h0, dq_oe}, 17'h0);
    bus_idle();

    // R3: oe low gives no drive
    @(negedge clk);
    cfg_en = 1; addr = mk_addr(1'b0, 1'b0, 16'h0);
    @(negedge clk);
    ce = 1; oe = 0;
    @(negedge clk);
    chk("R3 oe low keeps bus released", {16'h0, dq_oe}, 17'h0);
    bus_idle();

    // Random mix
    for (int i = 0; i < 300; i++) begin
      automatic int op = int'($urandom % 5);
      automatic logic pick = 1'($urandom);
      automatic logic id = ($urandom % 4) == 0;
      automatic logic [15:0] v = 16'($urandom);
      case (op)
        0: do_read(pick, id, "R3 random read");
        1: sync_write(int'($urandom % 3), pick, id, v);
        2: async_write(pick, id, v, 1'b1);
        3: async_write(pick, id, v, 1'b0);
        default: do_read(pick, 1'b0, "R8 random read after mixed lanes");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule